// File: doc/BRIEF.md
# Three-Channel Compare General Timer

This block is an up-counting timer with three compare channels. A small register port reaches all of its state. Several tick-enable strobes arrive from outside, and a three-bit source field in the control word picks one of them. A programmable divider then thins the chosen ticks before they reach the counter.

When the counter lands on a compare value, or on its all-ones value, a sticky status flag is raised, provided that flag's enable bit is set. Software clears a flag by writing a one to it. A single level interrupt is driven from the enabled flags.

The counter runs in one of two modes:

- Free-run mode: the counter wraps through zero.
- Restart mode: compare channel 1 sets the period.

A software reset clears the block while keeping the enable, mode and clock-source control bits. The two capture words hold no edge logic and simply read back as zero. The counter width is the parameter `CNT_W`, 32 by default. "All-ones" below means 0xFFFFFFFF at that default.

Top module: `cmp_timer`

## Requirements
- R1: Word addresses: 0 control, 1 divider, 2 status, 3 flag enable, 4/5/6 compare 1/2/3, 7/8 capture 1/2 (read zero), 9 counter (read only). Any other address reads zero, and writes to it change nothing.
- R2: The divider register is 12 bits. The counter advances once for every (divider + 1) selected ticks. Writing the divider register restarts the divide phase.
- R3: Control bits 8:6 choose the source. Code k counts strobe tick_i[k], and code 0 counts nothing. Strobes other than the chosen one have no effect.
- R4: Control bit 9 selects free-run mode. When set, the counter goes from all-ones to 0. When clear (restart mode), a count step taken while the counter equals compare 1 returns it to 0.
- R5: In restart mode, writing compare 1 sets the counter to 0. Writing compare 2 or compare 3 never alters the counter.
- R6: Status bits are: bit0–2 compare 1–3, bit3–4 capture, bit5 rollover. Writing 1 to a status bit clears it, and writing 0 leaves it alone. The flag-enable register keeps only bits 5:0.
- R7: A compare flag is set when a count step brings the counter to that channel's value while its enable bit is set. The rollover flag (bit5) is set the same way on reaching all-ones. Flags stay set until cleared.
- R8: irq_o is high exactly when (status AND enable) is nonzero and control bit 0 (enable) is set.
- R9: After hard reset, all registers read zero except the three compare words, which read all-ones.
- R10: Writing control with bit 15 set performs the reset of R9 on every register. The exceptions are control bits 8:0, which take the written value. Bit 15 and bit 9 read back 0.
- R11: Control bits 2, 4 and 10–14 always read zero.
- R12: Control bit 1 is enable-mode. When bit 0 rises while bit 1 is written as 1, the counter is cleared to 0. When bit 1 is 0, counting resumes from the held value.
- R13: The counter and the divider hold while control bit 0 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 8 | Tick-enable strobes, one per source code |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for addr_i |
| irq_o | output | 1 | Level interrupt |

## Verification
A register write takes effect at the clock edge that samples it. Read data is a combinational view of the registers, so the new value is due in the cycle after the write edge. A count step happens at the edge of the tick that completes a divide period. The matching status flag is set at that same edge, and irq_o follows in the same cycle. The bench therefore drives every write, read and tick just after a rising edge. Its monitor compares each queued expectation at the following falling edge, when every such result is already settled.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned PR_W   = 12;
  localparam int unsigned NCMP   = 3;
  localparam int unsigned SRC_W  = 3;
  localparam int unsigned NSRC   = 1 << SRC_W;
  localparam int unsigned FLAG_W = 6;

  // word addresses
  localparam logic [ADDR_W-1:0] A_CTRL     = 4'd0;
  localparam logic [ADDR_W-1:0] A_DIV      = 4'd1;
  localparam logic [ADDR_W-1:0] A_STAT     = 4'd2;
  localparam logic [ADDR_W-1:0] A_FEN      = 4'd3;
  localparam logic [ADDR_W-1:0] A_CMP_BASE = 4'd4;
  localparam logic [ADDR_W-1:0] A_CNT      = 4'd9;

  // control bit positions
  localparam int unsigned CB_EN    = 0;
  localparam int unsigned CB_EMODE = 1;
  localparam int unsigned CB_SRC   = 6;
  localparam int unsigned CB_FREE  = 9;
  localparam int unsigned CB_SRST  = 15;

  // status / enable bit positions
  localparam int unsigned FB_ROLL = 5;

  localparam logic [REG_W-1:0] CTRL_ZERO_MASK = 32'h0000_7C14;
  localparam logic [REG_W-1:0] CTRL_KEEP_MASK = 32'h0000_01FF;
endpackage

// File: rtl/cmp_timer_div.sv
module cmp_timer_div #(
  parameter int unsigned PR_W = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            clr_i,
  input  logic [PR_W-1:0] limit_i,
  output logic            step_o
);
  logic [PR_W-1:0] ph_q, ph_d;
  logic            wrap;

  assign wrap   = (ph_q == limit_i);
  assign step_o = run_i && !clr_i && wrap;

  always_comb begin
    ph_d = ph_q;
    if (clr_i)      ph_d = '0;
    else if (run_i) ph_d = wrap ? '0 : ph_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= '0;
    else         ph_q <= ph_d;
  end

  // R2: phase never passes the divide limit
  a_r2_phase_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q <= limit_i);
  // R2: a divider write restarts the phase
  a_r2_phase_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ph_q == '0);
endmodule

// File: rtl/cmp_timer_count.sv
module cmp_timer_count #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned NCMP  = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       step_i,
  input  logic                       clr_i,
  input  logic                       free_i,
  input  logic [NCMP-1:0][CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0]           cnt_o,
  output logic [NCMP-1:0]            hit_o,
  output logic                       roll_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_nxt;
  logic             adv;

  assign adv     = step_i && !clr_i;
  assign cnt_nxt = (!free_i && (cnt_q == cmp_i[0])) ? '0 : cnt_q + 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)     cnt_d = '0;
    else if (adv)  cnt_d = cnt_nxt;
  end

  for (genvar g = 0; g < NCMP; g++) begin : g_hit
    assign hit_o[g] = adv && (cnt_nxt == cmp_i[g]);
  end
  assign roll_o = adv && (&cnt_nxt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R4: restart mode returns to zero after compare 1
  a_r4_restart_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clr_i && !free_i && cnt_q == cmp_i[0]) |=> cnt_q == '0);
  // R4: otherwise a step adds one, wrapping through zero
  a_r4_step_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clr_i && (free_i || cnt_q != cmp_i[0])) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  // R13: no step, no clear: counter holds
  a_r13_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clr_i) |=> $stable(cnt_q));
  // R5: a clear request zeroes the counter
  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
  import cmp_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [REG_W-1:0]           wdata_i,
  input  logic [CNT_W-1:0]           cnt_i,
  input  logic [NCMP-1:0]            cmp_hit_i,
  input  logic                       roll_hit_i,
  output logic [REG_W-1:0]           rdata_o,
  output logic [REG_W-1:0]           ctrl_o,
  output logic [PR_W-1:0]            div_o,
  output logic [NCMP-1:0][CNT_W-1:0] cmp_o,
  output logic                       cnt_clr_o,
  output logic                       div_clr_o,
  output logic                       irq_o
);
  logic [REG_W-1:0]           ctrl_q, ctrl_d;
  logic [PR_W-1:0]            div_q, div_d;
  logic [FLAG_W-1:0]          sr_q, sr_d, fen_q, fen_d, set_vec;
  logic [NCMP-1:0][CNT_W-1:0] cmp_q, cmp_d;
  logic                       wr_ctrl, wr_div, wr_stat, wr_fen, soft_rst;
  logic                       en_rise, cmp1_restart;

  assign wr_ctrl  = we_i && (addr_i == A_CTRL);
  assign wr_div   = we_i && (addr_i == A_DIV);
  assign wr_stat  = we_i && (addr_i == A_STAT);
  assign wr_fen   = we_i && (addr_i == A_FEN);
  assign soft_rst = wr_ctrl && wdata_i[CB_SRST];

  assign en_rise      = wr_ctrl && !soft_rst && !ctrl_q[CB_EN] &&
                        wdata_i[CB_EN] && wdata_i[CB_EMODE];
  assign cmp1_restart = we_i && (addr_i == A_CMP_BASE) && !ctrl_q[CB_FREE];

  assign cnt_clr_o = soft_rst || en_rise || cmp1_restart;
  assign div_clr_o = soft_rst || wr_div;

  always_comb begin
    set_vec          = '0;
    set_vec[NCMP-1:0] = cmp_hit_i & fen_q[NCMP-1:0];
    set_vec[FB_ROLL] = roll_hit_i && fen_q[FB_ROLL];
  end

  always_comb begin
    ctrl_d = ctrl_q;
    div_d  = div_q;
    fen_d  = fen_q;
    cmp_d  = cmp_q;
    sr_d   = sr_q | set_vec;
    if (wr_stat) sr_d  = (sr_q & ~wdata_i[FLAG_W-1:0]) | set_vec;
    if (wr_ctrl) ctrl_d = wdata_i & ~CTRL_ZERO_MASK;
    if (wr_div)  div_d  = wdata_i[PR_W-1:0];
    if (wr_fen)  fen_d  = wdata_i[FLAG_W-1:0];
    for (int k = 0; k < NCMP; k++) begin
      if (we_i && (addr_i == ADDR_W'(A_CMP_BASE + k))) cmp_d[k] = wdata_i[CNT_W-1:0];
    end
    if (soft_rst) begin
      ctrl_d = wdata_i & ~CTRL_ZERO_MASK & CTRL_KEEP_MASK;
      div_d  = '0;
      fen_d  = '0;
      sr_d   = '0;
      for (int k = 0; k < NCMP; k++) cmp_d[k] = '1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      div_q  <= '0;
      fen_q  <= '0;
      sr_q   <= '0;
      cmp_q  <= '1;
    end else begin
      ctrl_q <= ctrl_d;
      div_q  <= div_d;
      fen_q  <= fen_d;
      sr_q   <= sr_d;
      cmp_q  <= cmp_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: rdata_o = ctrl_q;
      A_DIV:  rdata_o = REG_W'(div_q);
      A_STAT: rdata_o = REG_W'(sr_q);
      A_FEN:  rdata_o = REG_W'(fen_q);
      A_CNT:  rdata_o = REG_W'(cnt_i);
      default: begin
        for (int k = 0; k < NCMP; k++) begin
          if (addr_i == ADDR_W'(A_CMP_BASE + k)) rdata_o = REG_W'(cmp_q[k]);
        end
      end
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign div_o  = div_q;
  assign cmp_o  = cmp_q;
  assign irq_o  = ctrl_q[CB_EN] && (|(sr_q & fen_q));

  // R6: written ones clear, unless the same cycle sets the flag again
  a_r6_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stat |=> (sr_q & $past(wdata_i[FLAG_W-1:0]) & ~$past(set_vec)) == '0);
  // R7: flags are sticky without a clear
  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_stat && !soft_rst) |=> ($past(sr_q) & ~sr_q) == '0);
  // R10: software reset clears the non-control state
  a_r10_soft_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (sr_q == '0 && fen_q == '0 && div_q == '0 && !ctrl_q[CB_FREE]));
  // R11: reserved control bits stay zero
  a_r11_ctrl_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q & CTRL_ZERO_MASK) == '0 && !ctrl_q[CB_SRST]);
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   tick_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_o
);
  logic [1:0]                 rst_sync_q;
  logic                       rst_n;
  logic [REG_W-1:0]           ctrl;
  logic [PR_W-1:0]            div_lim;
  logic [NCMP-1:0][CNT_W-1:0] cmp;
  logic [CNT_W-1:0]           cnt;
  logic [NCMP-1:0]            hit;
  logic                       roll, cnt_clr, div_clr, step, run;
  logic [SRC_W-1:0]           src_sel;
  logic                       src_tick;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  assign src_sel  = ctrl[CB_SRC +: SRC_W];
  assign src_tick = (src_sel != '0) && tick_i[src_sel];
  assign run      = ctrl[CB_EN] && src_tick;

  cmp_timer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .cnt_i      (cnt),
    .cmp_hit_i  (hit),
    .roll_hit_i (roll),
    .rdata_o    (rdata_o),
    .ctrl_o     (ctrl),
    .div_o      (div_lim),
    .cmp_o      (cmp),
    .cnt_clr_o  (cnt_clr),
    .div_clr_o  (div_clr),
    .irq_o      (irq_o)
  );

  cmp_timer_div #(.PR_W(PR_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .run_i   (run),
    .clr_i   (div_clr),
    .limit_i (div_lim),
    .step_o  (step)
  );

  cmp_timer_count #(.CNT_W(CNT_W), .NCMP(NCMP)) u_count (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .step_i (step),
    .clr_i  (cnt_clr),
    .free_i (ctrl[CB_FREE]),
    .cmp_i  (cmp),
    .cnt_o  (cnt),
    .hit_o  (hit),
    .roll_o (roll)
  );

  // R13: no count step while disabled
  a_r13_step_needs_en: assert property (@(posedge clk_i) disable iff (!rst_n)
    !ctrl[CB_EN] |-> !step);
  // R8: interrupt only while enabled
  a_r8_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o |-> ctrl[CB_EN]);
endmodule

// File: tb/cmp_timer_tb.sv
module cmp_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [7:0]  tick_i;
  logic        we_i;
  logic [3:0]  addr_i;
  logic [31:0] wdata_i;
  logic [31:0] rdata_o;
  logic        irq_o;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } exp_t;

  exp_t q[$];
  bit   mon_req = 1'b0;
  bit   done = 1'b0;
  int   checks = 0;
  int   errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cmp_timer #(.CNT_W(CW)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  // monitor: pops expectations and compares at the falling edge
  always @(negedge clk_i) begin
    if (mon_req) begin
      exp_t it;
      logic [31:0] act;
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard empty actual=%h expected=none", rdata_o);
      end else begin
        it  = q.pop_front();
        act = it.is_irq ? {31'b0, irq_o} : rdata_o;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic cyc();
    @(posedge clk_i); #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    cyc();
    we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    exp_t it;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    addr_i = a;
    q.push_back(it);
    mon_req = 1'b1;
    cyc();
    mon_req = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    exp_t it;
    it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
    q.push_back(it);
    mon_req = 1'b1;
    cyc();
    mon_req = 1'b0;
  endtask

  task automatic ticks(input int n, input logic [7:0] m);
    tick_i = m;
    repeat (n) cyc();
    tick_i = '0;
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; tick_i = '0; we_i = 1'b0; addr_i = '0; wdata_i = '0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    repeat (3) cyc();

    // R9: hard reset values
    rd(4'd0, 32'h0, "R9 ctrl");
    rd(4'd1, 32'h0, "R9 divider");
    rd(4'd2, 32'h0, "R9 status");
    rd(4'd3, 32'h0, "R9 enable");
    rd(4'd4, 32'hFF, "R9 cmp1");
    rd(4'd5, 32'hFF, "R9 cmp2");
    rd(4'd6, 32'hFF, "R9 cmp3");
    rd(4'd9, 32'h0, "R9 counter");
    chk_irq(1'b0, "R9 irq");

    // R1: unmapped and capture addresses
    wr(4'd12, 32'hDEAD_BEEF);
    rd(4'd12, 32'h0, "R1 unmapped");
    wr(4'd7, 32'h1234_5678);
    rd(4'd7, 32'h0, "R1 capture1");
    rd(4'd8, 32'h0, "R1 capture2");
    wr(4'd9, 32'h55);
    rd(4'd9, 32'h0, "R1 counter read-only");

    // R11: reserved control bits
    wr(4'd0, 32'h0000_7E14);
    rd(4'd0, 32'h0000_0200, "R11 ctrl mask");

    // R2: divide by 3
    wr(4'd1, 32'hFFFF_F002);
    rd(4'd1, 32'h0000_0002, "R2 divider 12 bits");
    wr(4'd0, 32'h0000_0241);
    ticks(9, 8'h02);
    rd(4'd9, 32'd3, "R2 nine ticks");
    ticks(2, 8'h02);
    wr(4'd1, 32'h2);
    ticks(2, 8'h02);
    rd(4'd9, 32'd3, "R2 phase restart");
    ticks(1, 8'h02);
    rd(4'd9, 32'd4, "R2 period after restart");

    // R3: source selection
    ticks(6, 8'hFD);
    rd(4'd9, 32'd4, "R3 other strobes ignored");
    wr(4'd0, 32'h0000_0201);
    ticks(6, 8'hFF);
    rd(4'd9, 32'd4, "R3 code zero");

    // R13 / R12
    wr(4'd0, 32'h0000_0240);
    ticks(6, 8'hFF);
    rd(4'd9, 32'd4, "R13 hold while disabled");
    wr(4'd0, 32'h0000_0241);
    rd(4'd9, 32'd4, "R12 resume without enable-mode");
    wr(4'd0, 32'h0000_0240);
    wr(4'd0, 32'h0000_0243);
    rd(4'd9, 32'd0, "R12 clear with enable-mode");

    // R7 / R8 / R6: compare 2 in free-run
    wr(4'd1, 32'h0);
    wr(4'd3, 32'h07);
    wr(4'd5, 32'd5);
    rd(4'd9, 32'd0, "R5 cmp2 write keeps counter");
    ticks(5, 8'h02);
    rd(4'd2, 32'h02, "R7 cmp2 flag");
    chk_irq(1'b1, "R8 irq raised");
    ticks(1, 8'h02);
    rd(4'd2, 32'h02, "R7 sticky");
    wr(4'd2, 32'h01);
    rd(4'd2, 32'h02, "R6 write-one other bit");
    wr(4'd2, 32'h02);
    rd(4'd2, 32'h00, "R6 write-one clears");
    chk_irq(1'b0, "R8 irq cleared");
    wr(4'd3, 32'h01);
    wr(4'd5, 32'd8);
    ticks(2, 8'h02);
    rd(4'd9, 32'd8, "R7 counter at cmp2");
    rd(4'd2, 32'h00, "R7 disabled flag stays clear");
    wr(4'd3, 32'hFFFF_FFFF);
    rd(4'd3, 32'h3F, "R6 enable six bits");
    wr(4'd3, 32'h02);
    wr(4'd5, 32'd9);
    ticks(1, 8'h02);
    chk_irq(1'b1, "R8 irq on match");
    wr(4'd0, 32'h0000_0240);
    chk_irq(1'b0, "R8 irq gated by enable");
    rd(4'd2, 32'h02, "R8 flag kept while disabled");
    wr(4'd0, 32'h0000_0241);
    chk_irq(1'b1, "R8 irq back");
    wr(4'd2, 32'h3F);

    // R4 / R5: restart mode
    wr(4'd0, 32'h0000_0041);
    wr(4'd3, 32'h01);
    wr(4'd4, 32'd3);
    rd(4'd9, 32'd0, "R5 cmp1 write restarts");
    ticks(3, 8'h02);
    rd(4'd2, 32'h01, "R7 cmp1 flag");
    ticks(1, 8'h02);
    rd(4'd9, 32'd0, "R4 restart to zero");
    ticks(5, 8'h02);
    rd(4'd9, 32'd1, "R4 restart period");
    wr(4'd4, 32'd6);
    rd(4'd9, 32'd0, "R5 second cmp1 restart");
    ticks(2, 8'h02);
    wr(4'd6, 32'd100);
    rd(4'd9, 32'd2, "R5 cmp3 write keeps counter");
    wr(4'd5, 32'd50);
    rd(4'd9, 32'd2, "R5 cmp2 write keeps counter");
    wr(4'd2, 32'h3F);

    // R4 / R7: free-run rollover
    wr(4'd0, 32'h0000_0240);
    wr(4'd0, 32'h0000_0243);
    wr(4'd3, 32'h20);
    ticks(255, 8'h02);
    rd(4'd9, 32'hFF, "R4 counter at all-ones");
    rd(4'd2, 32'h20, "R7 rollover flag");
    ticks(1, 8'h02);
    rd(4'd9, 32'd0, "R4 free-run wrap");

    // R10: software reset
    wr(4'd1, 32'd5);
    wr(4'd3, 32'h3F);
    wr(4'd0, 32'h0000_826B);
    rd(4'd0, 32'h0000_006B, "R10 ctrl kept bits");
    rd(4'd1, 32'h0, "R10 divider");
    rd(4'd2, 32'h0, "R10 status");
    rd(4'd3, 32'h0, "R10 enable");
    rd(4'd4, 32'hFF, "R10 cmp1");
    rd(4'd6, 32'hFF, "R10 cmp3");
    chk_irq(1'b0, "R10 irq");
    ticks(2, 8'h02);
    rd(4'd9, 32'd2, "R10 still counting");

    repeat (2) cyc();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule